// File: doc/BRIEF.md
# DRAM Refresh Timer (CAS-before-RAS)

This block keeps DRAM contents alive by issuing periodic CAS-before-RAS refresh cycles. An interval counter advances once for each pulse of a reference-clock enable. When the programmed interval has elapsed, the block raises a refresh request towards the memory arbiter. Once the arbiter grants the bus, the block drives a refresh cycle on the active-low row and column strobes. The cycle lasts a programmable number of bus clocks, and `busy` stays high for its whole length.

Three fields of the global memory configuration set its behaviour: an 8-bit interval count, a refresh enable and a 2-bit cycle-length code. The interval counter keeps running while a request waits and while a refresh cycle is under way, so the spacing between refresh requests does not depend on how fast the arbiter grants. If the interval runs out again before the previous request has been served, a sticky missed-refresh flag is raised.

Top module: `dref_timer`

## Requirements
- R1: After reset, `refresh_req`, `busy` and `missed` are 0 and every `ras_n` and `cas_n` lane is 1. All strobes stay at 1 whenever no refresh cycle is running.
- R2: With `cfg_enable` high, `refresh_req` rises after (`cfg_count`+1)*4 cycles in which `ref_tick` is 1, counted from enable or from the previous expiry. Cycles with `ref_tick` at 0 do not advance the interval.
- R3: While `cfg_enable` is 0, no request is raised. A pending request is dropped in the cycle after `cfg_enable` falls.
- R4: A raised request stays high until it is accepted. Acceptance is a cycle in which `refresh_req` and `grant` are both 1 and `busy` is 0.
- R5: An accepted request starts a cycle in which `busy` is high for a number of clocks set by `cfg_cycle`, sampled at acceptance: 2'b00 gives 8, 2'b01 gives 6, 2'b10 gives 5 and 2'b11 gives 4.
- R6: Within a refresh cycle, all CAS lanes go low in the first clock and all RAS lanes go low in the second. Both sets return high together in the final clock. All lanes of each strobe move together.
- R7: Expiry reloads the interval counter, and the counter keeps counting while the request waits and while the refresh runs. The time between consecutive requests does not depend on grant latency.
- R8: `missed` is set when an expiry occurs while an earlier request is still pending and not being accepted. It then stays set until `cfg_enable` is cleared.
- R9: Clearing `cfg_enable` restarts the interval. After enable is set again, a full (`cfg_count`+1)*4 ticks pass before the next request.
- R10: A refresh cycle that has started always runs to its full length, even if `cfg_enable` is cleared during it.
- R11: `grant` has no effect while no request is pending. It starts no refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock enable, once per reference-clock period |
| cfg_count | input | CNT_W | Interval count; interval is (value+1)*4 ticks |
| cfg_enable | input | 1 | Refresh enable |
| cfg_cycle | input | 2 | Refresh cycle length code |
| grant | input | 1 | Bus grant from the memory arbiter |
| refresh_req | output | 1 | Refresh request to the arbiter |
| busy | output | 1 | High for every clock of a refresh cycle |
| missed | output | 1 | Sticky missed-refresh flag |
| ras_n | output | NUM_RAS | Active-low row strobes, one per bank |
| cas_n | output | NUM_CAS | Active-low column strobes, one per byte lane |

## Verification
The hardest case to reach from the ports is an expiry that lands while a refresh is pending or running. Reaching it needs grant latency and the tick stream to be controlled together. The bench holds `ref_tick` high on every clock, delays the grant by a few clocks and measures the distance to the next request, which checks that the counter keeps running. It then withholds the grant through a second interval to force the missed-refresh flag. A scoreboard receives the expected cycle length at each grant and compares it against the strobe waveform captured during `busy`. The bench also clears enable in the middle of a cycle and confirms that the cycle still completes.

// File: rtl/dref_pkg.sv
package dref_pkg;
  localparam int SEQ_W = 4;
  typedef logic [SEQ_W-1:0] seq_len_t;

  // refresh cycle length in bus clocks for each 2-bit code
  function automatic seq_len_t cyc_len(input logic [1:0] code);
    case (code)
      2'b00:   cyc_len = seq_len_t'(8);
      2'b01:   cyc_len = seq_len_t'(6);
      2'b10:   cyc_len = seq_len_t'(5);
      default: cyc_len = seq_len_t'(4);
    endcase
  endfunction
endpackage

// File: rtl/dref_interval.sv
module dref_interval #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int TOT_W = CNT_W + PRE_W;
  localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

  logic [TOT_W-1:0] cnt_q, cnt_d, limit;

  // limit = (count+1)*2^PRE_W - 1, so the match spans (count+1)*4 ticks
  assign limit  = {count, {PRE_W{1'b1}}};
  assign expire = en & tick & (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)          cnt_d = '0;
    else if (expire)  cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dref_request.sv
module dref_request (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic expire,
  input  logic start,
  output logic req,
  output logic missed
);
  logic req_q, req_d, miss_q, miss_d;

  always_comb begin
    req_d  = en & ((req_q & ~start) | expire);
    miss_d = en & (miss_q | (expire & req_q & ~start));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      miss_q <= miss_d;
    end
  end

  assign req    = req_q;
  assign missed = miss_q;
endmodule

// File: rtl/dref_sequencer.sv
module dref_sequencer
  import dref_pkg::*;
#(
  parameter int NUM_RAS = 4,
  parameter int NUM_CAS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cyc_code,
  output logic               busy,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_CAS-1:0] cas_n
);
  logic     busy_q, busy_d;
  seq_len_t phase_q, phase_d, last_q, last_d;
  logic     cas_on_d, ras_on_d;
  logic [NUM_RAS-1:0] ras_q;
  logic [NUM_CAS-1:0] cas_q;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    last_d  = last_q;
    if (start) begin
      busy_d  = 1'b1;
      phase_d = '0;
      last_d  = cyc_len(cyc_code) - seq_len_t'(1);
    end else if (busy_q) begin
      if (phase_q == last_q) begin
        busy_d  = 1'b0;
        phase_d = '0;
      end else begin
        phase_d = phase_q + seq_len_t'(1);
      end
    end
  end

  // column first, row one clock later, both released in the last clock
  always_comb begin
    cas_on_d = busy_d & (phase_d != last_d);
    ras_on_d = busy_d & (phase_d != '0) & (phase_d != last_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      last_q  <= '0;
      cas_q   <= '1;
      ras_q   <= '1;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      last_q  <= last_d;
      cas_q   <= {NUM_CAS{~cas_on_d}};
      ras_q   <= {NUM_RAS{~ras_on_d}};
    end
  end

  assign busy  = busy_q;
  assign ras_n = ras_q;
  assign cas_n = cas_q;
endmodule

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 2,
  parameter int NUM_RAS = 4,
  parameter int NUM_CAS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic               cfg_enable,
  input  logic [1:0]         cfg_cycle,
  input  logic               grant,
  output logic               refresh_req,
  output logic               busy,
  output logic               missed,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_CAS-1:0] cas_n
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       expire, start;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign start = refresh_req & grant & ~busy;

  dref_interval #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_interval (
    .clk(clk), .rst_n(rst_s), .en(cfg_enable), .tick(ref_tick),
    .count(cfg_count), .expire(expire)
  );

  dref_request u_request (
    .clk(clk), .rst_n(rst_s), .en(cfg_enable), .expire(expire),
    .start(start), .req(refresh_req), .missed(missed)
  );

  dref_sequencer #(.NUM_RAS(NUM_RAS), .NUM_CAS(NUM_CAS)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .cyc_code(cfg_cycle),
    .busy(busy), .ras_n(ras_n), .cas_n(cas_n)
  );
endmodule

// File: rtl/dref_timer_chk.sv
module dref_timer_chk #(
  parameter int NUM_RAS = 4,
  parameter int NUM_CAS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_enable,
  input logic               grant,
  input logic               refresh_req,
  input logic               busy,
  input logic               missed,
  input logic [NUM_RAS-1:0] ras_n,
  input logic [NUM_CAS-1:0] cas_n
);
  logic [4:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!busy)             run_q <= '0;
    else if (run_q != 5'd31)    run_q <= run_q + 5'd1;
  end

  assert_strobes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&ras_n && &cas_n));

  assert_no_req_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !refresh_req);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && cfg_enable && !(grant && !busy)) |=> refresh_req);

  assert_busy_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 5'd8);

  assert_cas_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n[0] && $past(ras_n[0])) |-> !$past(cas_n[0]));

  assert_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cas_n) == 0 || $countones(cas_n) == NUM_CAS) &&
    ($countones(ras_n) == 0 || $countones(ras_n) == NUM_RAS));

  assert_missed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (missed && cfg_enable) |=> missed);

  assert_start_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(refresh_req && grant));
endmodule

bind dref_timer dref_timer_chk #(.NUM_RAS(NUM_RAS), .NUM_CAS(NUM_CAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .grant(grant),
  .refresh_req(refresh_req), .busy(busy), .missed(missed),
  .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/sim_dref_timer.sv
`timescale 1ns/1ps
module sim_dref_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [7:0] cfg_count = 8'd0;
  logic       cfg_enable = 1'b0;
  logic [1:0] cfg_cycle = 2'b00;
  logic       grant = 1'b0;
  logic       refresh_req, busy, missed;
  logic [3:0] ras_n, cas_n;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  dref_timer u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_count(cfg_count),
    .cfg_enable(cfg_enable), .cfg_cycle(cfg_cycle), .grant(grant),
    .refresh_req(refresh_req), .busy(busy), .missed(missed),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: capture strobes during busy, compare with scoreboard entry
  int run = 0;
  bit lane_bad = 0;
  bit idle_bad = 0;
  logic [15:0] cas_h = '0, ras_h = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (run < 16) begin
          cas_h[run] = cas_n[0];
          ras_h[run] = ras_n[0];
        end
        if (cas_n != {4{cas_n[0]}} || ras_n != {4{ras_n[0]}}) lane_bad = 1;
        run++;
      end else begin
        if (!(&cas_n && &ras_n)) idle_bad = 1;
        if (run > 0) begin
          if (exp_q.size() == 0) begin
            check(0, "R11 unexpected cycle", run, 0);
          end else begin
            int len;
            bit pat_ok;
            len = exp_q.pop_front();
            check(run == len, "R5 cycle length", run, len);
            pat_ok = 1;
            for (int p = 0; p < len && p < 16; p++) begin
              if (cas_h[p] != (p == len - 1)) pat_ok = 0;
              if (ras_h[p] != (p == 0 || p == len - 1)) pat_ok = 0;
            end
            check(pat_ok && !lane_bad, "R6 strobe pattern", int'(pat_ok && !lane_bad), 1);
          end
          run = 0;
          lane_bad = 0;
        end
      end
    end
  end

  // deliver ticks with gap idle clocks between them until a request appears
  task automatic wait_req(input int gap, output int n);
    n = 0;
    while (!refresh_req && n < 2000) begin
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
      n++;
      repeat (gap) @(negedge clk);
    end
  endtask

  function automatic int len_of(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 6;
      2'b10:   return 5;
      default: return 4;
    endcase
  endfunction

  task automatic do_grant(input logic [1:0] code);
    cfg_cycle = code;
    exp_q.push_back(len_of(code));
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(refresh_req == 0 && busy == 0 && missed == 0, "R1 reset flags",
          int'({refresh_req, busy, missed}), 0);
    check(&ras_n && &cas_n, "R1 reset strobes", int'({ras_n, cas_n}), 255);

    // R2 interval with ticks every clock, count 2 -> 12 ticks; then 8-clock cycle
    cfg_count = 8'd2; cfg_enable = 1'b1;
    wait_req(0, n);
    check(n == 12, "R2 interval count 2", n, 12);
    do_grant(2'b00);
    check(refresh_req == 0, "R4 request cleared on accept", refresh_req, 0);
    wait_idle();

    // R2 with gapped ticks, count 0 -> 4 ticks
    cfg_enable = 1'b0; @(negedge clk);
    cfg_count = 8'd0; cfg_enable = 1'b1;
    wait_req(1, n);
    check(n == 4, "R2 interval gapped", n, 4);

    // R3 dropping enable removes the request and blocks new ones
    cfg_enable = 1'b0; @(negedge clk);
    check(refresh_req == 0, "R3 request dropped", refresh_req, 0);
    ref_tick = 1'b1;
    k = 0;
    repeat (40) begin
      @(negedge clk);
      if (refresh_req) k++;
    end
    ref_tick = 1'b0;
    check(k == 0, "R3 no request while disabled", k, 0);

    // R9 partial interval discarded by disable
    cfg_count = 8'd1; cfg_enable = 1'b1;
    repeat (3) begin
      ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
    end
    check(refresh_req == 0, "R9 no early request", refresh_req, 0);
    cfg_enable = 1'b0; @(negedge clk);
    cfg_enable = 1'b1;
    wait_req(0, n);
    check(n == 8, "R9 full interval after re-enable", n, 8);

    // R5 remaining length codes
    do_grant(2'b01); wait_idle();
    wait_req(0, n);
    check(n == 8, "R2 interval count 1", n, 8);
    do_grant(2'b10); wait_idle();
    wait_req(0, n);
    do_grant(2'b11); wait_idle();

    // R11 grant without a pending request
    grant = 1'b1;
    k = 0;
    repeat (3) begin
      @(negedge clk);
      if (busy) k++;
    end
    grant = 1'b0;
    check(k == 0, "R11 grant without request", k, 0);

    // R7 counter runs on across grant delay and refresh
    cfg_enable = 1'b0; @(negedge clk);
    cfg_count = 8'd3; cfg_enable = 1'b1;
    ref_tick = 1'b1;
    k = 0;
    while (!refresh_req && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(k == 16, "R2 interval count 3", k, 16);
    check(missed == 0, "R8 no miss on first expiry", missed, 0);
    repeat (3) @(negedge clk);
    do_grant(2'b11);
    k = 4;
    while (!refresh_req && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(k == 16, "R7 spacing independent of grant delay", k, 16);

    // R8 missed flag on second expiry without grant; R4 hold meanwhile
    n = 0;
    repeat (15) begin
      @(negedge clk);
      if (!refresh_req) n++;
    end
    check(missed == 0, "R8 not yet missed", missed, 0);
    check(n == 0, "R4 request held", n, 0);
    @(negedge clk);
    check(missed == 1, "R8 missed set", missed, 1);
    ref_tick = 1'b0;
    repeat (5) @(negedge clk);
    check(missed == 1, "R8 missed sticky", missed, 1);
    cfg_enable = 1'b0; @(negedge clk);
    check(missed == 0 && refresh_req == 0, "R8 cleared by disable",
          int'({missed, refresh_req}), 0);

    // R10 cycle completes after enable drops mid-cycle
    cfg_count = 8'd0; cfg_enable = 1'b1;
    wait_req(0, n);
    do_grant(2'b00);
    @(negedge clk);
    cfg_enable = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(refresh_req == 0, "R10 no request after disable", refresh_req, 0);

    check(exp_q.size() == 0, "R5 all cycles observed", exp_q.size(), 0);
    check(!idle_bad, "R1 strobes idle outside cycles", int'(idle_bad), 0);
    finish_run();
  end
endmodule